// File: doc/BRIEF.md
# Redundant Route and Arbitration Checker

This block guards the route-computation and switch-allocation stage of a router pipeline against transient upsets by computing each result twice. When a flit enters the stage, the next-port value and the grant vector from the combinational computation units are captured. In the following cycle the units are asked to compute again for the same flit, and each new result is compared with its first copy. If both copies agree, the first results are released to crossbar traversal in the next cycle, with no extra delay.

If either pair disagrees, the block stalls the pipeline for one recovery cycle. It asks only the unit whose results disagreed to compute a third time. For each field that disagreed, it releases a bitwise 2-of-3 majority of the three copies. A field whose copies agreed is released from its first copy. A one-cycle error pulse, with separate route and grant flags, marks every recovery for statistics.

Upstream logic presents a new flit only while both recompute strobes and the stall are low, and keeps the flit under computation steady while any of them is high. A new flit may start in the same cycle that the previous result is on the crossbar outputs.

Top module: `rcsa_guard`

## Requirements
- R1: After reset, all outputs are low: the recompute strobes, the stall, the crossbar valid, the crossbar route and grant, the error pulse and both error flags.
- R2: In a cycle where flit_valid is high and both strobes and the stall are low, the inputs are taken as the first computation. In the next cycle, redo_route and redo_grant are both high.
- R3: If both second results equal the first results, xbar_valid is high for one cycle in the cycle after the second computation, with xbar_route and xbar_grant equal to the first results. No stall occurs and all error outputs stay low.
- R4: If the route pair differs, redo_route is high in the recovery cycle. If the grant pair differs, redo_grant is high in the recovery cycle. A field whose pair matched has its strobe low in that cycle.
- R5: In the recovery cycle, err_pulse is high for exactly that cycle. err_route is high exactly when the route pair differed, and err_grant is high exactly when the grant pair differed.
- R6: A mismatch raises stall for exactly one cycle: the cycle after the second computation. xbar_valid follows in the cycle after the stall.
- R7: After a recovery, each field whose pair differed is released as the bitwise majority of its first, second and third copies. A field whose pair matched is released as its first copy, and the third value on its input is ignored.
- R8: xbar_valid is never high for two cycles in a row. A new flit may be accepted in the cycle where xbar_valid is high, and its result is unaffected by the previous flit.
- R9: flit_valid is ignored while either strobe or the stall is high: no extra result appears and the flit sequence is not disturbed.
- R10: With flit_valid low in the idle state, no strobe, stall, result or error output rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_valid | input | 1 | A flit is ready for its first computation |
| route_in | input | RW | Next-port result from the route unit this cycle |
| grant_in | input | GW | Grant vector from the allocator this cycle |
| redo_route | output | 1 | Route unit must recompute the held flit |
| redo_grant | output | 1 | Allocator must recompute the held flit |
| stall | output | 1 | Pipeline hold during the recovery cycle |
| xbar_valid | output | 1 | Final result valid for crossbar traversal |
| xbar_route | output | RW | Final next-port value |
| xbar_grant | output | GW | Final grant vector |
| err_pulse | output | 1 | One-cycle pulse per detected mismatch |
| err_route | output | 1 | Route pair differed |
| err_grant | output | 1 | Grant pair differed |

## Verification
The bench sweeps every route value against several error masks on both fields. This covers clean flits, route-only errors, grant-only errors, errors on both fields, and third copies that disagree with both earlier copies in some bits. A design that voted word-wise instead of bit-wise, or voted a field that had matched, would release a wrong value when the third input was deliberately corrupted. A design that recomputed both units on any mismatch would show a wrong strobe in the recovery cycle. A design that started the next flit during recovery, or kept xbar_valid high for two cycles, would lose or duplicate a flit across the back-to-back sequence. flit_valid is held high during the second computation and the recovery cycle to catch designs that accept it there.

// File: rtl/rcsa_guard.sv
module rcsa_guard #(
  parameter int RW = 3,
  parameter int GW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flit_valid,
  input  logic [RW-1:0] route_in,
  input  logic [GW-1:0] grant_in,
  output logic          redo_route,
  output logic          redo_grant,
  output logic          stall,
  output logic          xbar_valid,
  output logic [RW-1:0] xbar_route,
  output logic [GW-1:0] xbar_grant,
  output logic          err_pulse,
  output logic          err_route,
  output logic          err_grant
);

  typedef enum logic [1:0] {PH_FIRST, PH_SECOND, PH_RECOVER} phase_t;

  phase_t        ph;
  logic [RW-1:0] r_a, r_b;
  logic [GW-1:0] g_a, g_b;
  logic          mis_r, mis_g;

  wire r_diff = route_in != r_a;
  wire g_diff = grant_in != g_a;

  wire [RW-1:0] r_vote = (r_a & r_b) | (r_a & route_in) | (r_b & route_in);
  wire [GW-1:0] g_vote = (g_a & g_b) | (g_a & grant_in) | (g_b & grant_in);

  assign stall      = ph == PH_RECOVER;
  assign redo_route = (ph == PH_SECOND) || (stall && mis_r);
  assign redo_grant = (ph == PH_SECOND) || (stall && mis_g);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph         <= PH_FIRST;
      r_a        <= '0;
      r_b        <= '0;
      g_a        <= '0;
      g_b        <= '0;
      mis_r      <= 1'b0;
      mis_g      <= 1'b0;
      xbar_valid <= 1'b0;
      xbar_route <= '0;
      xbar_grant <= '0;
      err_pulse  <= 1'b0;
      err_route  <= 1'b0;
      err_grant  <= 1'b0;
    end else begin
      xbar_valid <= 1'b0;
      err_pulse  <= 1'b0;
      err_route  <= 1'b0;
      err_grant  <= 1'b0;
      case (ph)
        PH_FIRST: if (flit_valid) begin
          r_a <= route_in;
          g_a <= grant_in;
          ph  <= PH_SECOND;
        end
        PH_SECOND: begin
          r_b   <= route_in;
          g_b   <= grant_in;
          mis_r <= r_diff;
          mis_g <= g_diff;
          if (r_diff || g_diff) begin
            ph        <= PH_RECOVER;
            err_pulse <= 1'b1;
            err_route <= r_diff;
            err_grant <= g_diff;
          end else begin
            ph         <= PH_FIRST;
            xbar_valid <= 1'b1;
            xbar_route <= r_a;
            xbar_grant <= g_a;
          end
        end
        default: begin
          ph         <= PH_FIRST;
          xbar_valid <= 1'b1;
          xbar_route <= mis_r ? r_vote : r_a;
          xbar_grant <= mis_g ? g_vote : g_a;
        end
      endcase
    end
  end

endmodule

// File: rtl/rcsa_guard_chk.sv
module rcsa_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic flit_valid,
  input logic redo_route,
  input logic redo_grant,
  input logic stall,
  input logic xbar_valid,
  input logic err_pulse,
  input logic err_route,
  input logic err_grant
);

  a_r2_redo_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && !redo_route && !redo_grant && !stall) |=> (redo_route && redo_grant));

  a_r3_clean_or_recover: assert property (@(posedge clk) disable iff (!rst_n)
    (redo_route && redo_grant && !stall) |=> (xbar_valid || stall));

  a_r4_selective_redo: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (redo_route == err_route && redo_grant == err_grant));

  a_r5_pulse_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> stall);

  a_r6_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!stall && xbar_valid));

  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xbar_valid |=> !xbar_valid);

endmodule

bind rcsa_guard rcsa_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid),
  .redo_route(redo_route), .redo_grant(redo_grant), .stall(stall),
  .xbar_valid(xbar_valid), .err_pulse(err_pulse),
  .err_route(err_route), .err_grant(err_grant)
);

// File: tb/sim_rcsa_guard.sv
module sim_rcsa_guard;
  localparam int RW = 3;
  localparam int GW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flit_valid = 1'b0;
  logic [RW-1:0] route_in = '0;
  logic [GW-1:0] grant_in = '0;
  logic          redo_route, redo_grant, stall, xbar_valid;
  logic [RW-1:0] xbar_route;
  logic [GW-1:0] xbar_grant;
  logic          err_pulse, err_route, err_grant;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rcsa_guard #(.RW(RW), .GW(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid),
    .route_in(route_in), .grant_in(grant_in),
    .redo_route(redo_route), .redo_grant(redo_grant), .stall(stall),
    .xbar_valid(xbar_valid), .xbar_route(xbar_route), .xbar_grant(xbar_grant),
    .err_pulse(err_pulse), .err_route(err_route), .err_grant(err_grant)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [GW-1:0] maj(input logic [GW-1:0] a, b, c);
    logic [GW-1:0] m;
    for (int k = 0; k < GW; k++)
      m[k] = (int'(a[k]) + int'(b[k]) + int'(c[k])) >= 2;
    return m;
  endfunction

  // Called at a negedge with the block idle; returns at the negedge where
  // the result is on the outputs, which is also the next flit's first cycle.
  task automatic run_flit(input logic [RW-1:0] r1, r2, r3,
                          input logic [GW-1:0] g1, g2, g3);
    logic          mr, mg;
    logic [RW-1:0] er;
    logic [GW-1:0] eg;
    mr = r1 != r2;
    mg = g1 != g2;
    er = mr ? RW'(maj(GW'(r1), GW'(r2), GW'(r3))) : r1;
    eg = mg ? maj(g1, g2, g3) : g1;
    flit_valid = 1'b1; route_in = r1; grant_in = g1;
    chk("R2 idle strobes", {redo_route, redo_grant, stall}, 0);
    @(negedge clk);
    chk("R2 second compute", {redo_route, redo_grant, stall}, 3'b110);
    chk("R8 no back-to-back valid", xbar_valid, 0);
    route_in = r2; grant_in = g2;
    @(negedge clk);
    if (mr || mg) begin
      chk("R6 stall in recovery", stall, 1);
      chk("R4 selective redo", {redo_route, redo_grant}, {mr, mg});
      chk("R5 error flags", {err_pulse, err_route, err_grant}, {1'b1, mr, mg});
      chk("R6 no result during stall", xbar_valid, 0);
      route_in = r3; grant_in = g3;
      @(negedge clk);
      chk("R6 valid after stall", xbar_valid, 1);
      chk("R7 voted route", xbar_route, er);
      chk("R7 voted grant", xbar_grant, eg);
    end else begin
      chk("R3 clean valid", xbar_valid, 1);
      chk("R3 clean route", xbar_route, r1);
      chk("R3 clean grant", xbar_grant, g1);
      chk("R3 no error no stall", {stall, err_pulse, err_route, err_grant}, 0);
    end
    chk("R5 error pulse ends", {err_pulse, err_route, err_grant}, 0);
    flit_valid = 1'b0;
  endtask

  initial begin
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {redo_route, redo_grant, stall, xbar_valid, xbar_route,
        xbar_grant, err_pulse, err_route, err_grant}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    repeat (4) begin
      chk("R10 idle quiet", {redo_route, redo_grant, stall, xbar_valid, err_pulse}, 0);
      @(negedge clk);
    end
    for (int i = 0; i < 512; i++) begin
      logic [RW-1:0] r1, rm, r3;
      logic [GW-1:0] g1, g2, g3;
      r1 = RW'(i);
      rm = RW'(i >> 3);
      r3 = r1 ^ RW'((i * 5) >> 2);
      g1 = GW'(i * 37 + 11);
      g2 = ((i >> 6) % 3 == 0) ? g1 : (g1 ^ GW'(1 << (i % GW)) ^ GW'((i >> 7) & 2));
      g3 = g1 ^ GW'((i * 3) >> 1);
      run_flit(r1, r1 ^ rm, r3, g1, g2, g3);
    end
    // R9: flit_valid held high while the block is busy must not add flits
    run_flit(3'd5, 3'd2, 3'd7, 7'h55, 7'h55, 7'h00);
    run_flit(3'd1, 3'd1, 3'd6, 7'h0f, 7'h0f, 7'h70);
    @(negedge clk);
    chk("R9 R10 no extra result", {xbar_valid, redo_route, redo_grant, stall}, 0);
    @(negedge clk);
    chk("R9 R10 still quiet", {xbar_valid, redo_route, redo_grant, stall}, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule